// File: doc/BRIEF.md
# Chime Strike Relay Sequencer

This block turns a chime request into a train of timed pulses on one relay output. A request carries a strike count and a half-hour flag. An hour request strikes the relay once for each count. Each strike holds the relay on for a fixed pulse time and is followed by a fixed silent gap. A half-hour request strikes once and finishes as soon as the pulse ends, with no gap after it.

All durations are counted in tick enables, which normally arrive at 1 kHz. The block holds `busy` high while it has work. A request that arrives while a train is running waits in a single pending slot and starts when the current train ends. A later valid request replaces whatever is waiting in that slot.

Top module: `strike_relay_seq`

## Requirements
- R1: After synchronous reset, `relay_on` and `busy` are both low.
- R2: An hour request (`req_half`=0) with `req_count` from 1 to 12 produces exactly that many relay pulses. Each pulse is high for PULSE_TICKS tick enables.
- R3: Every pulse of an hour train is followed by GAP_TICKS tick enables with the relay low, including the last pulse. Busy stays high through each gap.
- R4: A half-hour request (`req_half`=1, `req_count` ignored) produces exactly one pulse. `busy` falls in the cycle right after that pulse, with no gap.
- R5: An hour request with `req_count` of 0 or 13 to 15 is ignored. It causes no pulse, leaves `busy` low when idle, and does not disturb a request already pending.
- R6: A request is taken on a clock edge where `req_valid` is high. `busy` is high from the next cycle. `relay_on` rises one cycle after `busy`. `relay_on` is never high while `busy` is low. With a tick on every cycle, busy lasts 1+n·(PULSE_TICKS+GAP_TICKS) cycles for an n-strike hour train and 1+PULSE_TICKS cycles for a half-hour train.
- R7: A valid request accepted while busy is held and started after the current train ends. `busy` stays high across the hand-over, which adds one launch cycle.
- R8: Only one request can be pending. A newer valid request overwrites an older one that has not yet started.
- R9: Timing advances only on cycles with `tick_en` high. With no ticks, the relay and busy outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base enable, one per time unit |
| req_valid | input | 1 | Chime request strobe |
| req_count | input | 4 | Number of hour strikes, 1 to 12 |
| req_half | input | 1 | Half-hour request; overrides the count |
| relay_on | output | 1 | Relay drive, high while striking |
| busy | output | 1 | High while a train runs or a request waits |

## Verification
The hardest situation to reach is a pending slot that sees several requests in turn while a train is running. The slot must keep the newest valid request, drop out-of-range ones, and launch without a break in `busy`.

The bench starts a long hour train. While the train runs, it injects further requests: an out-of-range one after a valid one, and a chain of valid ones. It then checks the total pulse count and the unbroken busy length against the closed-form sums. A separate test stops the tick during a pulse to show that the outputs freeze and that the remaining pulse length is still exact.

// File: rtl/strike_pkg.sv
package strike_pkg;

    localparam int CNT_W       = 4;
    localparam int MAX_STRIKES = 12;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PULSE = 2'd1,
        SEQ_GAP   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic             half;
        logic [CNT_W-1:0] count;
    } chime_req_t;

    function automatic logic req_acceptable(chime_req_t r);
        return r.half || ((r.count != '0) && (r.count <= CNT_W'(MAX_STRIKES)));
    endfunction

    function automatic logic [CNT_W-1:0] strikes_for(chime_req_t r);
        return r.half ? CNT_W'(1) : r.count;
    endfunction

endpackage

// File: rtl/strike_req_slot.sv
module strike_req_slot
    import strike_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  chime_req_t in_req,
    input  logic       take,
    output logic       slot_valid,
    output chime_req_t slot_req
);

    logic in_ok;
    assign in_ok = in_valid && req_acceptable(in_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_valid <= 1'b0;
            slot_req   <= '0;
        end else if (in_ok) begin
            slot_valid <= 1'b1;
            slot_req   <= in_req;
        end else if (take) begin
            slot_valid <= 1'b0;
        end
    end

    // R5: a rejected request leaves the pending slot untouched
    a_r5_reject_keeps_slot: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !req_acceptable(in_req) && !take) |=> ($stable(slot_valid) && $stable(slot_req)));

    // R8: a newer valid request lands in the slot
    a_r8_newest_wins: assert property (@(posedge clk) disable iff (rst)
        in_ok |=> (slot_valid && slot_req == $past(in_req)));

endmodule

// File: rtl/strike_tick_timer.sv
module strike_tick_timer #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);

    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (tick_en && remain != '0) begin
            remain <= remain - W'(1);
        end
    end

    assign expire = tick_en && (remain == W'(1));

    // R9: without a tick and without a reload the count stays put
    a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !load) |=> $stable(remain));

endmodule

// File: rtl/strike_seq_fsm.sv
module strike_seq_fsm
    import strike_pkg::*;
#(
    parameter int PULSE_TICKS = 120,
    parameter int GAP_TICKS   = 1500,
    parameter int TW          = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slot_valid,
    input  chime_req_t    slot_req,
    input  logic          expire,
    input  logic          tick_en,
    output logic          take,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          active,
    output logic          striking
);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic             half_q, half_d;

    always_comb begin
        state_d  = state_q;
        left_d   = left_q;
        half_d   = half_q;
        take     = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = TW'(PULSE_TICKS);
        unique case (state_q)
            SEQ_IDLE: begin
                if (slot_valid) begin
                    take     = 1'b1;
                    tmr_load = 1'b1;
                    left_d   = strikes_for(slot_req);
                    half_d   = slot_req.half;
                    state_d  = SEQ_PULSE;
                end
            end
            SEQ_PULSE: begin
                if (expire) begin
                    if (half_q) begin
                        state_d = SEQ_IDLE;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = TW'(GAP_TICKS);
                        state_d  = SEQ_GAP;
                    end
                end
            end
            SEQ_GAP: begin
                if (expire) begin
                    if (left_q == CNT_W'(1)) begin
                        state_d = SEQ_IDLE;
                    end else begin
                        left_d   = left_q - CNT_W'(1);
                        tmr_load = 1'b1;
                        state_d  = SEQ_PULSE;
                    end
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            left_q  <= '0;
            half_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            half_q  <= half_d;
        end
    end

    assign active   = (state_q != SEQ_IDLE);
    assign striking = (state_q == SEQ_PULSE);

    // R4: a half-hour pulse never enters a gap
    a_r4_half_no_gap: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_PULSE && half_q) |=> (state_q != SEQ_GAP));

    // R2: the strike counter stays inside 1..12 while running
    a_r2_left_in_range: assert property (@(posedge clk) disable iff (rst)
        (state_q != SEQ_IDLE) |-> (left_q != '0 && left_q <= CNT_W'(MAX_STRIKES)));

    // R9: a running train only moves on a tick
    a_r9_state_frozen: assert property (@(posedge clk) disable iff (rst)
        (state_q != SEQ_IDLE && !tick_en) |=> $stable(state_q));

endmodule

// File: rtl/strike_relay_seq.sv
module strike_relay_seq
    import strike_pkg::*;
#(
    parameter int PULSE_TICKS = 120,
    parameter int GAP_TICKS   = 1500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] req_count,
    input  logic             req_half,
    output logic             relay_on,
    output logic             busy
);

    localparam int LONGEST = (PULSE_TICKS > GAP_TICKS) ? PULSE_TICKS : GAP_TICKS;
    localparam int TW      = $clog2(LONGEST + 1);

    chime_req_t    in_req, slot_req;
    logic          slot_valid, take, tmr_load, expire, active, striking;
    logic [TW-1:0] tmr_val;

    assign in_req = '{half: req_half, count: req_count};

    strike_req_slot u_slot (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (req_valid),
        .in_req     (in_req),
        .take       (take),
        .slot_valid (slot_valid),
        .slot_req   (slot_req)
    );

    strike_seq_fsm #(
        .PULSE_TICKS (PULSE_TICKS),
        .GAP_TICKS   (GAP_TICKS),
        .TW          (TW)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .slot_valid (slot_valid),
        .slot_req   (slot_req),
        .expire     (expire),
        .tick_en    (tick_en),
        .take       (take),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .active     (active),
        .striking   (striking)
    );

    strike_tick_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (expire)
    );

    assign relay_on = striking;
    assign busy     = active || slot_valid;

    // R6: relay never drives outside a busy period
    a_r6_relay_inside_busy: assert property (@(posedge clk) disable iff (rst)
        relay_on |-> busy);

    // R6: an accepted request raises busy on the next cycle
    a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_acceptable(in_req)) |=> busy);

endmodule

// File: tb/tb_strike_relay_seq.sv
module tb_strike_relay_seq;

    localparam int P = 4;
    localparam int G = 7;
    localparam int NV = 8;
    // each entry: [8] half, [7:4] count, [3:0] expected pulses
    localparam logic [8:0] VEC [NV] = '{
        {1'b0, 4'd1,  4'd1},
        {1'b0, 4'd4,  4'd4},
        {1'b0, 4'd12, 4'd12},
        {1'b1, 4'd0,  4'd1},
        {1'b1, 4'd7,  4'd1},
        {1'b0, 4'd0,  4'd0},
        {1'b0, 4'd13, 4'd0},
        {1'b0, 4'd15, 4'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_en = 1'b1;
    logic req_valid = 1'b0;
    logic [3:0] req_count = '0;
    logic req_half = 1'b0;
    logic relay_on, busy;

    int errors = 0;
    int checks = 0;

    bit mon_en = 1'b0;
    int busy_c, high_c, low_c, rises, maxw, curw, idx, fb, fr;
    logic prev_relay;

    always #2 clk = ~clk;

    strike_relay_seq #(.PULSE_TICKS(P), .GAP_TICKS(G)) dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .req_valid(req_valid),
        .req_count(req_count), .req_half(req_half),
        .relay_on(relay_on), .busy(busy)
    );

    always @(negedge clk) begin
        if (!mon_en) begin
            busy_c = 0; high_c = 0; low_c = 0; rises = 0; maxw = 0;
            curw = 0; idx = 0; fb = -1; fr = -1; prev_relay = 1'b0;
        end else begin
            if (busy) busy_c++;
            if (relay_on) high_c++;
            if (busy && !relay_on) low_c++;
            if (relay_on && !prev_relay) rises++;
            if (relay_on) curw++;
            else curw = 0;
            if (curw > maxw) maxw = curw;
            if (busy && fb < 0) fb = idx;
            if (relay_on && fr < 0) fr = idx;
            idx++;
            prev_relay = relay_on;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int cnt, input bit half);
        @(negedge clk);
        req_valid = 1'b1; req_count = 4'(cnt); req_half = half;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic mon_start();
        @(posedge clk); #1 mon_en = 1'b1;
    endtask

    task automatic mon_stop();
        @(posedge clk); #1 mon_en = 1'b0;
    endtask

    task automatic wait_end(input bit expect_busy);
        bit seen = 1'b0;
        for (int i = 0; i < (expect_busy ? 4000 : 20); i++) begin
            @(negedge clk);
            if (seen && !busy) break;
            if (busy) seen = 1'b1;
        end
    endtask

    initial begin
        #300000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 relay", int'(relay_on), 0);
        check("R1 busy", int'(busy), 0);
        @(negedge clk) rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            automatic bit h = VEC[v][8];
            automatic int c = int'(VEC[v][7:4]);
            automatic int n = int'(VEC[v][3:0]);
            automatic int eb = (n == 0) ? 0 : (h ? 1 + P : 1 + n * (P + G));
            automatic int el = (n == 0) ? 0 : (h ? 1 : 1 + n * G);
            mon_start();
            send(c, h);
            wait_end(n != 0);
            mon_stop();
            if (n == 0) begin
                check("R5 no pulse", rises, 0);
                check("R5 busy stays low", busy_c, 0);
            end else begin
                check(h ? "R4 single pulse" : "R2 pulse count", rises, n);
                check("R2 pulse width", maxw, P);
                check("R2 high time", high_c, n * P);
                check(h ? "R4 no gap" : "R3 gap time", low_c, el);
                check("R6 busy length", busy_c, eb);
                check("R6 relay one cycle after busy", fr - fb, 1);
            end
        end

        // R5 and R7: queued valid request runs, later out-of-range one is dropped
        mon_start();
        send(3, 1'b0);
        repeat (10) @(negedge clk);
        send(2, 1'b0);
        repeat (2) @(negedge clk);
        send(13, 1'b0);
        wait_end(1'b1);
        mon_stop();
        check("R7 queued pulses", rises, 5);
        check("R5 pending kept", high_c, 5 * P);
        check("R7 busy unbroken", busy_c, 2 + 5 * (P + G));

        // R8: newest pending request replaces older one
        mon_start();
        send(1, 1'b0);
        repeat (2) @(negedge clk);
        send(6, 1'b0);
        repeat (2) @(negedge clk);
        send(2, 1'b0);
        wait_end(1'b1);
        mon_stop();
        check("R8 overwrite pulses", rises, 3);
        check("R8 busy length", busy_c, 2 + 3 * (P + G));

        // R9: no ticks freezes a half-hour pulse
        @(negedge clk) tick_en = 1'b0;
        send(0, 1'b1);
        repeat (30) @(negedge clk);
        check("R9 relay held", int'(relay_on), 1);
        check("R9 busy held", int'(busy), 1);
        tick_en = 1'b1;
        begin
            automatic int hc = 0;
            for (int i = 0; i < 50; i++) begin
                if (!relay_on) break;
                hc++;
                @(negedge clk);
            end
            check("R9 remaining pulse", hc, P);
            check("R4 busy drops with pulse", int'(busy), 0);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule